// File: doc/BRIEF.md
# Programming Command Framer with Instruction Unpacker

This block sits behind a word-wide serial link on which a programming master sends 16-bit command words. It groups the incoming words into commands, checks each command's length against the value fixed for its opcode, pulls out the count and address fields, and turns packed 24-bit instruction payloads into single instructions. Those instructions are issued one at a time on a simple memory request port that answers with an acknowledge, a fail flag and read data.

Each command is answered with a response frame. The first response word carries a fixed tag, the echoed opcode and a status or query byte. The second word gives the response length in words. A read command follows these two words with the requested instructions, packed back into the same three-words-per-pair layout. While a memory request is open, the block stops accepting input words. Every response word is held on the output until the receiver takes it.

Top module: `prog_cmd_framer`

## Requirements
- R1: The first word of a command carries the opcode in bits 15:12 and the total command length in words, header included, in bits 11:0. The fixed lengths are 1 for opcode 0h, 4 for opcode 2h, 51 for opcode 5h and 1 for opcode Bh. Every other opcode is invalid.
- R2: Opcode 0h (sanity check) is answered with 1000h followed by 0002h.
- R3: Opcode Bh (version query) is answered with {1h, Bh, VERSION} followed by 0002h.
- R4: A command with an invalid opcode, or whose length field differs from the fixed value, has its following (length − 1) words consumed without any memory access. It is answered with {1h, opcode, 02h} and 0002h, and the next word is taken as a new header.
- R5: For opcode 5h, word 1 bits 7:0 give address bits 23:16 and word 2 gives address bits 15:0. Each group of three data words (a, b, c) yields instruction 0 = {b[7:0], a} and instruction 1 = {b[15:8], c}.
- R6: The 32 instructions of an opcode 5h command are written at base, base+2, base+4 and so on, in that order. All 32 writes are issued even when one fails. The response is {1h, 5h, 00h} when all writes pass, {1h, 5h, 01h} when any write fails, and in both cases 0002h.
- R7: For opcode 2h, word 1 is the instruction count N, word 2 bits 7:0 give address bits 23:16 and word 3 gives address bits 15:0. An N of 0 or above 32768 is answered with {1h, 2h, 02h} and 0002h, with no reads. Otherwise the header is {1h, 2h, 00h} and the length word is 2 + 3·floor(N/2) + 2·(N mod 2).
- R8: Read data follows the header. Reads go to base, base+2 and so on. Each pair is sent as a[15:0], {b[23:16], a[23:16]}, b[15:0]. A final odd instruction is sent as a[15:0], {00h, a[23:16]}.
- R9: A memory request holds its address, direction and write data steady until it is acknowledged. rx_ready is low while a request is open.
- R10: While tx_valid is high and tx_ready is low, tx_valid and tx_word do not change.
- R11: After reset, rx_ready is 1, tx_valid is 0 and mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Command word offered |
| rx_word | input | 16 | Command word |
| rx_ready | output | 1 | Block takes the offered word this cycle |
| tx_valid | output | 1 | Response word present |
| tx_word | output | 16 | Response word |
| tx_ready | input | 1 | Receiver takes the response word |
| mem_req | output | 1 | Memory request open |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Instruction address |
| mem_wdata | output | 24 | Instruction to write |
| mem_ack | input | 1 | Request completes this cycle |
| mem_fail | input | 1 | Write failed (valid with mem_ack) |
| mem_rdata | input | 24 | Read instruction (valid with mem_ack) |

## Verification
The bench goes after several corner cases.
- Length checking: a wrong length on a valid opcode, an unknown opcode, and a zero length. Skipping words by the wrong count would make the block lose framing, so the following sanity check would get a garbled answer.
- Odd read counts: a missing pad word or a wrong length word would shift every later response word.
- Byte order: swapped upper bytes in the unpacker or the packer would show up as wrong write data or wrong read words.
- Write failure: a failure in the middle of a row must still leave all 32 writes issued and set the fail status. A design that stopped early would leave writes missing, and one that cleared the status would report a pass.
- Stalls: memory acknowledge delays and receiver stalls are mixed in, so that words lost or doubled at a handshake are caught.

// File: rtl/pcf_pkg.sv
`timescale 1ns/1ps
package pcf_pkg;
  localparam int WORD_W  = 16;
  localparam int INSTR_W = 24;
  localparam int ADDR_W  = 24;
  localparam int LEN_W   = 12;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [INSTR_W-1:0] instr_t;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [LEN_W-1:0]   len_t;

  localparam logic [3:0] OP_SANITY  = 4'h0;
  localparam logic [3:0] OP_READ    = 4'h2;
  localparam logic [3:0] OP_ROWPROG = 4'h5;
  localparam logic [3:0] OP_VERSION = 4'hB;
  localparam logic [3:0] RESP_TAG   = 4'h1;

  localparam logic [7:0] ST_PASS = 8'h00;
  localparam logic [7:0] ST_FAIL = 8'h01;
  localparam logic [7:0] ST_BAD  = 8'h02;

  localparam logic [15:0] MAX_READ = 16'h8000;

  typedef enum logic [3:0] {
    S_HDR, S_FLD, S_DROP, S_WR0, S_WR1, S_RESP, S_RD0, S_RD1, S_EMIT
  } fsm_t;

  // Fixed command length per opcode; zero marks an invalid opcode.
  function automatic len_t expected_len(input logic [3:0] op, input int row_instr);
    case (op)
      OP_SANITY, OP_VERSION: return len_t'(1);
      OP_READ:               return len_t'(4);
      OP_ROWPROG:            return len_t'(3 + (row_instr * 3) / 2);
      default:               return '0;
    endcase
  endfunction

  function automatic word_t hdr_word(input logic [3:0] op, input logic [7:0] st);
    return {RESP_TAG, op, st};
  endfunction

  // Words in a read response: header pair, three per pair, two for an odd tail.
  function automatic word_t read_resp_len(input logic [15:0] n);
    logic [16:0] t;
    t = 17'd2 + 17'(n[15:1]) * 17'd3 + {15'd0, n[0], 1'b0};
    return t[15:0];
  endfunction

  function automatic logic read_count_ok(input logic [15:0] n);
    return (n != 16'd0) && (n <= MAX_READ);
  endfunction
endpackage

// File: rtl/pcf_unpack.sv
`timescale 1ns/1ps
module pcf_unpack
  import pcf_pkg::*;
(
  input  word_t  w0,
  input  word_t  w1,
  input  word_t  w2,
  output instr_t ia,
  output instr_t ib
);
  assign ia = {w1[7:0],  w0};
  assign ib = {w1[15:8], w2};
endmodule

// File: rtl/pcf_pack.sv
`timescale 1ns/1ps
module pcf_pack
  import pcf_pkg::*;
(
  input  instr_t ia,
  input  instr_t ib,
  input  logic   odd,
  output word_t  p0,
  output word_t  p1,
  output word_t  p2
);
  assign p0 = ia[15:0];
  assign p1 = odd ? {8'h00, ia[23:16]} : {ib[23:16], ia[23:16]};
  assign p2 = ib[15:0];
endmodule

// File: rtl/pcf_txreg.sv
`timescale 1ns/1ps
module pcf_txreg
  import pcf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  word_t ld_word,
  output logic  ld_ok,
  output logic  tx_valid,
  output word_t tx_word,
  input  logic  tx_ready
);
  assign ld_ok = !tx_valid || tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else if (ld_ok) begin
      tx_valid <= ld;
      if (ld) tx_word <= ld_word;
    end
  end

  // R10: a stalled response word stays put
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_word));
endmodule

// File: rtl/prog_cmd_framer.sv
`timescale 1ns/1ps
module prog_cmd_framer
  import pcf_pkg::*;
#(
  parameter int         ROW_INSTR = 32,
  parameter int         ADDR_STEP = 2,
  parameter logic [7:0] VERSION   = 8'h23
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [15:0] tx_word,
  input  logic        tx_ready,
  output logic        mem_req,
  output logic        mem_wr,
  output logic [23:0] mem_addr,
  output logic [23:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_fail,
  input  logic [23:0] mem_rdata
);
  localparam addr_t STEP = addr_t'(ADDR_STEP);

  fsm_t        st;
  logic [3:0]  op_q;
  len_t        len_q, widx, drop_cnt;
  addr_t       addr_q;
  logic [15:0] n_q, nrem;
  logic [7:0]  status_q;
  word_t       g0, g1, g2;
  logic [1:0]  grp_pos, eidx;
  instr_t      ia_q, ib_q;
  logic        odd_q;

  // named events for assertions
  logic rx_fire, mem_done, wr_done_ev, rd_done_ev, ld, ld_ok, ld_fire, emit_last;
  logic [3:0] hdr_op;
  len_t hdr_len, hdr_exp;
  logic hdr_bad;
  word_t ld_word, resp_len_w, p0, p1, p2;
  instr_t ia_u, ib_u;

  assign rx_ready   = (st == S_HDR) || (st == S_FLD) || (st == S_DROP);
  assign rx_fire    = rx_valid && rx_ready;
  assign mem_req    = (st == S_WR0) || (st == S_WR1) || (st == S_RD0) || (st == S_RD1);
  assign mem_wr     = (st == S_WR0) || (st == S_WR1);
  assign mem_addr   = addr_q;
  assign mem_done   = mem_req && mem_ack;
  assign wr_done_ev = mem_done && mem_wr;
  assign rd_done_ev = mem_done && !mem_wr;

  assign hdr_op  = rx_word[15:12];
  assign hdr_len = rx_word[11:0];
  assign hdr_exp = expected_len(hdr_op, ROW_INSTR);
  assign hdr_bad = (hdr_exp == '0) || (hdr_len != hdr_exp);

  pcf_unpack u_unpack (.w0(g0), .w1(g1), .w2(g2), .ia(ia_u), .ib(ib_u));
  pcf_pack   u_pack   (.ia(ia_q), .ib(ib_q), .odd(odd_q), .p0(p0), .p1(p1), .p2(p2));

  assign mem_wdata = (st == S_WR1) ? ib_u : ia_u;

  assign resp_len_w = (op_q == OP_READ && status_q == ST_PASS) ? read_resp_len(n_q) : 16'd2;
  assign ld         = (st == S_RESP) || (st == S_EMIT);
  assign ld_fire    = ld && ld_ok;

  always_comb begin
    ld_word = p0;
    if (st == S_RESP) ld_word = (eidx == 2'd0) ? hdr_word(op_q, status_q) : resp_len_w;
    else if (eidx == 2'd1) ld_word = p1;
    else if (eidx == 2'd2) ld_word = p2;
  end

  assign emit_last = (st == S_RESP) ? (eidx == 2'd1) : (odd_q ? (eidx == 2'd1) : (eidx == 2'd2));

  pcf_txreg u_tx (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(ld_word), .ld_ok(ld_ok),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HDR; op_q <= '0; len_q <= '0; widx <= '0; drop_cnt <= '0;
      addr_q <= '0; n_q <= '0; nrem <= '0; status_q <= ST_PASS;
      g0 <= '0; g1 <= '0; g2 <= '0; grp_pos <= '0; eidx <= '0;
      ia_q <= '0; ib_q <= '0; odd_q <= 1'b0;
    end else begin
      case (st)
        S_HDR: if (rx_fire) begin
          op_q    <= hdr_op;
          len_q   <= hdr_len;
          widx    <= len_t'(1);
          grp_pos <= '0;
          eidx    <= '0;
          if (hdr_bad) begin
            status_q <= ST_BAD;
            if (hdr_len > len_t'(1)) begin
              drop_cnt <= hdr_len - len_t'(1);
              st       <= S_DROP;
            end else st <= S_RESP;
          end else begin
            status_q <= (hdr_op == OP_VERSION) ? VERSION : ST_PASS;
            st       <= (hdr_exp == len_t'(1)) ? S_RESP : S_FLD;
          end
        end
        S_DROP: if (rx_fire) begin
          drop_cnt <= drop_cnt - len_t'(1);
          if (drop_cnt == len_t'(1)) st <= S_RESP;
        end
        S_FLD: if (rx_fire) begin
          widx <= widx + len_t'(1);
          if (op_q == OP_READ) begin
            if (widx == len_t'(1)) n_q <= rx_word;
            else if (widx == len_t'(2)) addr_q[23:16] <= rx_word[7:0];
            else begin
              addr_q[15:0] <= rx_word;
              nrem         <= n_q;
              if (!read_count_ok(n_q)) status_q <= ST_BAD;
              st <= S_RESP;
            end
          end else begin
            if (widx == len_t'(1)) addr_q[23:16] <= rx_word[7:0];
            else if (widx == len_t'(2)) addr_q[15:0] <= rx_word;
            else begin
              case (grp_pos)
                2'd0: g0 <= rx_word;
                2'd1: g1 <= rx_word;
                default: begin g2 <= rx_word; st <= S_WR0; end
              endcase
              grp_pos <= (grp_pos == 2'd2) ? 2'd0 : grp_pos + 2'd1;
            end
          end
        end
        S_WR0: if (mem_ack) begin
          if (mem_fail) status_q <= ST_FAIL;
          addr_q <= addr_q + STEP;
          st     <= S_WR1;
        end
        S_WR1: if (mem_ack) begin
          if (mem_fail) status_q <= ST_FAIL;
          addr_q <= addr_q + STEP;
          st     <= (widx == len_q) ? S_RESP : S_FLD;
        end
        S_RESP: if (ld_ok) begin
          if (emit_last) begin
            eidx <= '0;
            st   <= (op_q == OP_READ && status_q == ST_PASS) ? S_RD0 : S_HDR;
          end else eidx <= eidx + 2'd1;
        end
        S_RD0: if (mem_ack) begin
          ia_q   <= mem_rdata;
          addr_q <= addr_q + STEP;
          nrem   <= nrem - 16'd1;
          odd_q  <= (nrem == 16'd1);
          st     <= (nrem == 16'd1) ? S_EMIT : S_RD1;
        end
        S_RD1: if (mem_ack) begin
          ib_q   <= mem_rdata;
          addr_q <= addr_q + STEP;
          nrem   <= nrem - 16'd1;
          st     <= S_EMIT;
        end
        S_EMIT: if (ld_ok) begin
          if (emit_last) begin
            eidx <= '0;
            st   <= (nrem == 16'd0) ? S_HDR : S_RD0;
          end else eidx <= eidx + 2'd1;
        end
        default: st <= S_HDR;
      endcase
    end
  end

  // R9: open request keeps its contents until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wr) && $stable(mem_wdata));

  // R9: no input word is taken while memory is busy
  a_r9_rx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready);

  // R6: back-to-back writes step the address upward
  a_r6_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_done_ev) && mem_req && mem_wr |-> mem_addr == $past(mem_addr) + STEP);

  // R8: back-to-back reads step the address upward
  a_r8_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_done_ev) && mem_req && !mem_wr |-> mem_addr == $past(mem_addr) + STEP);

  // R11: idle after reset
  a_r11_idle: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |=> rx_ready && !tx_valid && !mem_req);
endmodule

// File: tb/tb_prog_cmd_framer.sv
`timescale 1ns/1ps
module tb_prog_cmd_framer;
  localparam logic [7:0] VER = 8'h3C;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_word = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [15:0] tx_word;
  logic        tx_ready = 1'b1;
  logic        mem_req, mem_wr;
  logic [23:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_fail = 1'b0;
  logic [23:0] mem_rdata = '0;

  prog_cmd_framer #(.VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_fail(mem_fail), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, wr_count = 0, rd_count = 0;
  logic [15:0] exp_w[$];
  string       exp_t[$];
  logic [23:0] ew_addr[$], ew_data[$], er_addr[$];
  logic [23:0] mem [logic [23:0]];
  logic [23:0] fail_addr = 24'hFFFFFF;
  int          wait_cnt = 0, lat = 0;
  logic        held_v = 1'b0;
  logic [15:0] held_w = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: response scoreboard and stall checks
  always @(negedge clk) begin
    cyc++;
    tx_ready = (cyc % 5) != 4;
    if (rst_n) begin
      if (held_v) chk("R10 stalled word held", {15'd0, tx_valid, tx_word}, {15'd0, 1'b1, held_w});
      held_v = tx_valid && !tx_ready;
      held_w = tx_word;
      if (tx_valid && tx_ready) begin
        if (exp_w.size() == 0) chk("response word not expected", {16'd0, tx_word}, 32'hFFFF_FFFF);
        else chk(exp_t.pop_front(), {16'd0, tx_word}, {16'd0, exp_w.pop_front()});
      end
    end
  end

  // memory model with rotating acknowledge latency
  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        chk("R9 rx_ready low during request", {31'd0, rx_ready}, 32'd0);
        if (mem_wr) begin
          wr_count++;
          mem_fail = (mem_addr == fail_addr);
          if (!mem_fail) mem[mem_addr] = mem_wdata;
          if (ew_addr.size() == 0) chk("R6 write not expected", {8'd0, mem_addr}, 32'hFFFF_FFFF);
          else begin
            chk("R6 write address", {8'd0, mem_addr}, {8'd0, ew_addr.pop_front()});
            chk("R5 unpacked write data", {8'd0, mem_wdata}, {8'd0, ew_data.pop_front()});
          end
        end else begin
          rd_count++;
          mem_fail = 1'b0;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 24'h0;
          if (er_addr.size() == 0) chk("R8 read not expected", {8'd0, mem_addr}, 32'hFFFF_FFFF);
          else chk("R8 read address", {8'd0, mem_addr}, {8'd0, er_addr.pop_front()});
        end
        wait_cnt = lat;
        lat = (lat + 1) % 3;
      end else begin
        mem_ack = 1'b0;
        wait_cnt--;
      end
    end else mem_ack = 1'b0;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic send(input logic [15:0] w);
    logic took;
    rx_valid = 1'b1;
    rx_word  = w;
    forever begin
      took = rx_ready;
      @(negedge clk);
      if (took) break;
    end
    rx_valid = 1'b0;
  endtask

  task automatic expect_resp(input logic [3:0] op, input logic [7:0] s, input logic [15:0] len, input string tag);
    exp_w.push_back({4'h1, op, s}); exp_t.push_back({tag, " header"});
    exp_w.push_back(len);           exp_t.push_back({tag, " length"});
  endtask

  task automatic drain();
    while (exp_w.size() != 0 || ew_addr.size() != 0 || er_addr.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [23:0] instr_val(input logic [23:0] seed, input int i);
    return seed ^ (24'(i) * 24'h031507);
  endfunction

  task automatic rowprog(input logic [23:0] base, input logic [23:0] seed, input logic [7:0] st_exp, input string tag);
    for (int i = 0; i < 32; i++) begin
      ew_addr.push_back(base + 24'(2 * i));
      ew_data.push_back(instr_val(seed, i));
    end
    expect_resp(4'h5, st_exp, 16'h0002, tag);
    send(16'h5033);
    send({8'h00, base[23:16]});
    send(base[15:0]);
    for (int j = 0; j < 16; j++) begin
      logic [23:0] a, b;
      a = instr_val(seed, 2 * j);
      b = instr_val(seed, 2 * j + 1);
      send(a[15:0]);
      send({b[23:16], a[23:16]});
      send(b[15:0]);
    end
  endtask

  task automatic readp(input logic [23:0] base, input logic [15:0] n, input string tag);
    logic [15:0] dq[$];
    if (n == 16'd0 || n > 16'h8000) expect_resp(4'h2, 8'h02, 16'h0002, tag);
    else begin
      for (int k = 0; k < int'(n); k += 2) begin
        logic [23:0] a, b;
        a = mem[base + 24'(2 * k)];
        er_addr.push_back(base + 24'(2 * k));
        dq.push_back(a[15:0]);
        if (k + 1 < int'(n)) begin
          b = mem[base + 24'(2 * k + 2)];
          er_addr.push_back(base + 24'(2 * k + 2));
          dq.push_back({b[23:16], a[23:16]});
          dq.push_back(b[15:0]);
        end else dq.push_back({8'h00, a[23:16]});
      end
      expect_resp(4'h2, 8'h00, 16'(dq.size() + 2), tag);
      foreach (dq[i]) begin exp_w.push_back(dq[i]); exp_t.push_back({tag, " data"}); end
    end
    send(16'h2004);
    send(n);
    send({8'h00, base[23:16]});
    send(base[15:0]);
  endtask

  initial begin
    int wc, rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rx_ready after reset", {31'd0, rx_ready}, 32'd1);
    chk("R11 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
    chk("R11 mem_req after reset", {31'd0, mem_req}, 32'd0);

    expect_resp(4'h0, 8'h00, 16'h0002, "R2 R1 sanity");
    send(16'h0001); drain();
    expect_resp(4'hB, VER, 16'h0002, "R3 version");
    send(16'hB001); drain();

    wc = wr_count; rc = rd_count;
    expect_resp(4'h0, 8'h02, 16'h0002, "R4 wrong length op0");
    send(16'h0003); send(16'h5033); send(16'h2004); drain();
    expect_resp(4'h7, 8'h02, 16'h0002, "R4 unknown opcode");
    send(16'h7002); send(16'h0001); drain();
    expect_resp(4'h2, 8'h02, 16'h0002, "R4 R1 read length 5");
    send(16'h2005); send(16'h0001); send(16'h0000); send(16'h0000); send(16'h0000); drain();
    expect_resp(4'h5, 8'h02, 16'h0002, "R4 zero length");
    send(16'h5000); drain();
    chk("R4 no writes from bad commands", 32'(wr_count), 32'(wc));
    chk("R4 no reads from bad commands", 32'(rd_count), 32'(rc));
    expect_resp(4'h0, 8'h00, 16'h0002, "R4 resync sanity");
    send(16'h0001); drain();

    rowprog(24'h012340, 24'hA5C3E1, 8'h00, "R6 row pass"); drain();
    wc = wr_count;
    fail_addr = 24'h3F000A;
    rowprog(24'h3F0000, 24'h5A1234, 8'h01, "R6 row fail"); drain();
    chk("R6 all writes after failure", 32'(wr_count - wc), 32'd32);
    fail_addr = 24'hFFFFFF;

    readp(24'h012340, 16'd5, "R7 R8 read odd"); drain();
    readp(24'h012350, 16'd4, "R7 R8 read even"); drain();
    readp(24'h012344, 16'd1, "R8 read single"); drain();
    rc = rd_count;
    readp(24'h012340, 16'd0, "R7 read zero"); drain();
    readp(24'h012340, 16'h8001, "R7 read too many"); drain();
    chk("R7 no reads for bad count", 32'(rd_count), 32'(rc));

    chk("R2 response queue empty", 32'(exp_w.size()), 32'd0);
    summary();
    $finish;
  end
endmodule